// File: doc/BRIEF.md
# Iterative Four-Direction Triple-Error Corrector

The block repairs a 64-bit data word laid out as an 8x8 grid. Each data bit sits on one row, one column, one rising diagonal and one falling diagonal. Alongside the word it receives four syndrome vectors, one per direction, that flag the lines whose recomputed parity differs from the stored parity. It also receives four flags that mark a direction whose stored parity bits are known to be damaged. For bit index `i`, the row is `i/8` and the column is `i%8`. The rising-diagonal line is `row+col`, in the range 0..14. The falling-diagonal line is `row-col+7`, in the range 0..14.

Each pulse on `start_i` loads a new problem. The block then works one round per clock. In a round it marks every bit where flagged lines from two usable directions cross, and prunes that candidate set. It then applies a fixed priority of selection rules and flips the single chosen bit. The flipped bit's four lines are toggled in the working syndromes, and the next round starts over from those syndromes. The block stops on one of three conditions: at most one usable line is still flagged, no rule selects a bit, or the round budget is spent. It then pulses `done_o` with the result flags.

Selection priority within a round is as follows. First comes a bit whose four lines are all flagged. Next comes a surviving candidate that is the only survivor on one of its flagged lines. Last comes a surviving candidate with at least three flagged lines. Ties go to the lowest bit index. A candidate is discarded when it is the only candidate on one of its unflagged usable lines. When the number of flagged rows equals the remaining round budget, candidates off the flagged rows are also discarded.

Top module: `tcc_corrector`

## Requirements
- R1: After reset `data_o`, `done_o`, `corrected_o` and `uncorrectable_o` are all 0.
- R2: A start pulse clears both result flags at the next edge. `done_o` is seen exactly F+2 clock edges after the edge that samples `start_i`, where F is the number of bits flipped, and F never exceeds 3. While idle, `data_o` holds its value.
- R3: With all four directions usable and exactly one data bit in error, the block restores the original word, sets `corrected_o` and clears `uncorrectable_o`.
- R4: With all four directions usable and any two distinct data bits in error, including pairs that share a line, the block restores the original word and sets `corrected_o`.
- R5: Bit `k` of `dir_bad_i` masks a direction, with 0 for row, 1 for column, 2 for rising diagonal and 3 for falling diagonal. The syndromes of a masked direction have no effect. A single data error is corrected whenever two or three directions stay usable.
- R6: When at most one usable line is flagged, the word is returned unchanged with both flags clear. This covers a clean input and a single error seen through only one usable direction.
- R7: When two or more usable lines are flagged but no selection rule picks a bit, the block stops with `uncorrectable_o` set, `corrected_o` clear and the word unflipped.
- R8: `done_o` lasts one cycle, and `corrected_o` and `uncorrectable_o` are never both set.
- R9: At most one data bit changes per clock. Once the round budget of 3 is used, no further bit changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Load the inputs and begin correction (ignored while busy) |
| data_i | input | 64 | Received data word |
| row_syn_i | input | 8 | Flagged rows |
| col_syn_i | input | 8 | Flagged columns |
| rise_syn_i | input | 15 | Flagged rising diagonals, line row+col |
| fall_syn_i | input | 15 | Flagged falling diagonals, line row-col+7 |
| dir_bad_i | input | 4 | Per-direction damaged-parity flags: row, col, rise, fall |
| data_o | output | 64 | Working / corrected word |
| done_o | output | 1 | One-cycle end-of-correction pulse |
| corrected_o | output | 1 | Ended clean after at least one flip |
| uncorrectable_o | output | 1 | Ended with flagged lines and no selectable bit |

## Verification
Two selection rules can both qualify in the same round. For two errors that share no line, both error bits carry four flagged lines and are also each the lone survivor on some line. The four-line rule must win, and ties must resolve to the lower index. For pairs that share a line, the four-line rule has no taker and the lone-survivor or three-line rule must act instead. The sweep over all 2016 error pairs provokes both situations. It judges them by the final word, the flags and the exact F+2 latency with F=2.

// File: rtl/tcc_pkg.sv
package tcc_pkg;
  typedef enum logic {ST_IDLE, ST_RUN} tcc_state_e;

  localparam int DIR_ROW  = 0;
  localparam int DIR_COL  = 1;
  localparam int DIR_RISE = 2;
  localparam int DIR_FALL = 3;
  localparam int NDIR     = 4;

  // line index of grid bit i in direction d
  function automatic int line_of(int d, int i, int side);
    int r, c;
    r = i / side;
    c = i % side;
    case (d)
      DIR_ROW:  return r;
      DIR_COL:  return c;
      DIR_RISE: return r + c;
      default:  return r - c + side - 1;
    endcase
  endfunction
endpackage

// File: rtl/tcc_hits.sv
module tcc_hits #(
  parameter int SIDE = 8,
  localparam int N  = SIDE * SIDE,
  localparam int ND = 2 * SIDE - 1
) (
  input  logic [SIDE-1:0]    row_i,
  input  logic [SIDE-1:0]    col_i,
  input  logic [ND-1:0]      rise_i,
  input  logic [ND-1:0]      fall_i,
  input  logic [3:0]         use_i,
  output logic [N-1:0][3:0]  hit_o,
  output logic [N-1:0]       cand_o
);
  for (genvar r = 0; r < SIDE; r++) begin : g_r
    for (genvar c = 0; c < SIDE; c++) begin : g_c
      localparam int I = r * SIDE + c;
      assign hit_o[I] = {use_i[3] & fall_i[r-c+SIDE-1],
                         use_i[2] & rise_i[r+c],
                         use_i[1] & col_i[c],
                         use_i[0] & row_i[r]};
      assign cand_o[I] = ($countones(hit_o[I]) >= 2);
    end
  end
endmodule

// File: rtl/tcc_pick.sv
module tcc_pick
  import tcc_pkg::*;
#(
  parameter int SIDE   = 8,
  parameter int ROUNDS = 3,
  localparam int N  = SIDE * SIDE,
  localparam int ND = 2 * SIDE - 1,
  localparam int IW = $clog2(N),
  localparam int KW = $clog2(ROUNDS + 1),
  localparam int CW = $clog2(SIDE + 1)
) (
  input  logic [N-1:0][3:0] hit_i,
  input  logic [N-1:0]      cand_i,
  input  logic [SIDE-1:0]   row_use_i,
  input  logic [3:0]        use_i,
  input  logic [KW-1:0]     left_i,
  output logic              pick_vld_o,
  output logic [IW-1:0]     pick_idx_o
);
  logic [CW-1:0] n_cand [NDIR][ND];
  logic [CW-1:0] n_surv [NDIR][ND];
  logic [N-1:0]  surv, lone, four, three, sel;
  logic          row_gate;

  assign row_gate = (left_i != '0) && ($countones(row_use_i) == int'(left_i));

  always_comb begin
    for (int d = 0; d < NDIR; d++)
      for (int l = 0; l < ND; l++) begin
        n_cand[d][l] = '0;
        n_surv[d][l] = '0;
      end
    for (int i = 0; i < N; i++)
      if (cand_i[i])
        for (int d = 0; d < NDIR; d++)
          n_cand[d][line_of(d, i, SIDE)] = n_cand[d][line_of(d, i, SIDE)] + CW'(1);
    // prune: alone on an unflagged usable line, or off the flagged rows
    for (int i = 0; i < N; i++) begin
      logic disc;
      disc = 1'b0;
      for (int d = 0; d < NDIR; d++)
        if (use_i[d] && !hit_i[i][d] && n_cand[d][line_of(d, i, SIDE)] == CW'(1))
          disc = 1'b1;
      surv[i] = cand_i[i] && !disc && (!row_gate || hit_i[i][DIR_ROW]);
    end
    for (int i = 0; i < N; i++)
      if (surv[i])
        for (int d = 0; d < NDIR; d++)
          n_surv[d][line_of(d, i, SIDE)] = n_surv[d][line_of(d, i, SIDE)] + CW'(1);
    for (int i = 0; i < N; i++) begin
      lone[i] = 1'b0;
      for (int d = 0; d < NDIR; d++)
        if (surv[i] && hit_i[i][d] && n_surv[d][line_of(d, i, SIDE)] == CW'(1))
          lone[i] = 1'b1;
      four[i]  = cand_i[i] && (&hit_i[i]);
      three[i] = surv[i] && ($countones(hit_i[i]) >= 3);
    end
    if (|four)      sel = four;
    else if (|lone) sel = lone;
    else            sel = three;
    pick_vld_o = |sel;
    pick_idx_o = '0;
    for (int i = N - 1; i >= 0; i--)
      if (sel[i]) pick_idx_o = IW'(i);
  end
endmodule

// File: rtl/tcc_corrector.sv
module tcc_corrector
  import tcc_pkg::*;
#(
  parameter int SIDE   = 8,
  parameter int ROUNDS = 3,
  localparam int N  = SIDE * SIDE,
  localparam int ND = 2 * SIDE - 1,
  localparam int IW = $clog2(N),
  localparam int KW = $clog2(ROUNDS + 1),
  localparam int RW = $clog2(SIDE),
  localparam int DW = $clog2(ND)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            start_i,
  input  logic [N-1:0]    data_i,
  input  logic [SIDE-1:0] row_syn_i,
  input  logic [SIDE-1:0] col_syn_i,
  input  logic [ND-1:0]   rise_syn_i,
  input  logic [ND-1:0]   fall_syn_i,
  input  logic [3:0]      dir_bad_i,
  output logic [N-1:0]    data_o,
  output logic            done_o,
  output logic            corrected_o,
  output logic            uncorrectable_o
);
  tcc_state_e      state_q;
  logic [N-1:0]    data_q;
  logic [SIDE-1:0] row_q, col_q;
  logic [ND-1:0]   rise_q, fall_q;
  logic [3:0]      use_q;
  logic [KW-1:0]   round_q;
  logic            done_q, corr_q, unc_q;
  logic            busy;

  logic [N-1:0][3:0] hit;
  logic [N-1:0]      cand;
  logic [SIDE-1:0]   row_use;
  logic              pick_vld;
  logic [IW-1:0]     pick_idx;
  logic [KW-1:0]     left;
  logic              clean;
  logic [RW-1:0]     p_row, p_col;
  logic [DW-1:0]     p_rise, p_fall;

  assign busy    = (state_q == ST_RUN);
  assign row_use = row_q & {SIDE{use_q[DIR_ROW]}};
  assign left    = KW'(ROUNDS) - round_q;
  assign clean   = ($countones(row_use)
                  + $countones(col_q  & {SIDE{use_q[DIR_COL]}})
                  + $countones(rise_q & {ND{use_q[DIR_RISE]}})
                  + $countones(fall_q & {ND{use_q[DIR_FALL]}})) <= 1;

  always_comb begin
    int pi;
    pi     = int'(pick_idx);
    p_row  = RW'(pi / SIDE);
    p_col  = RW'(pi % SIDE);
    p_rise = DW'(pi / SIDE + pi % SIDE);
    p_fall = DW'(pi / SIDE - pi % SIDE + SIDE - 1);
  end

  tcc_hits #(.SIDE(SIDE)) u_hits (
    .row_i (row_q), .col_i (col_q), .rise_i(rise_q), .fall_i(fall_q),
    .use_i (use_q), .hit_o (hit),   .cand_o(cand)
  );

  tcc_pick #(.SIDE(SIDE), .ROUNDS(ROUNDS)) u_pick (
    .hit_i     (hit),     .cand_i    (cand),    .row_use_i (row_use),
    .use_i     (use_q),   .left_i    (left),
    .pick_vld_o(pick_vld), .pick_idx_o(pick_idx)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      data_q  <= '0;
      row_q   <= '0;
      col_q   <= '0;
      rise_q  <= '0;
      fall_q  <= '0;
      use_q   <= '0;
      round_q <= '0;
      done_q  <= 1'b0;
      corr_q  <= 1'b0;
      unc_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy) begin
        if (start_i) begin
          state_q <= ST_RUN;
          data_q  <= data_i;
          row_q   <= row_syn_i;
          col_q   <= col_syn_i;
          rise_q  <= rise_syn_i;
          fall_q  <= fall_syn_i;
          use_q   <= ~dir_bad_i;
          round_q <= '0;
          corr_q  <= 1'b0;
          unc_q   <= 1'b0;
        end
      end else if (clean) begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
        corr_q  <= (round_q != '0);
      end else if (pick_vld && round_q != KW'(ROUNDS)) begin
        data_q[pick_idx] <= ~data_q[pick_idx];
        row_q[p_row]     <= ~row_q[p_row];
        col_q[p_col]     <= ~col_q[p_col];
        rise_q[p_rise]   <= ~rise_q[p_rise];
        fall_q[p_fall]   <= ~fall_q[p_fall];
        round_q          <= round_q + KW'(1);
      end else begin
        state_q <= ST_IDLE;
        done_q  <= 1'b1;
        unc_q   <= 1'b1;
      end
    end
  end

  assign data_o          = data_q;
  assign done_o          = done_q;
  assign corrected_o     = corr_q;
  assign uncorrectable_o = unc_q;
endmodule

// File: rtl/tcc_checker.sv
module tcc_checker #(
  parameter int N      = 64,
  parameter int ROUNDS = 3,
  parameter int KW     = 2
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          start_i,
  input logic          busy_i,
  input logic [KW-1:0] round_i,
  input logic [N-1:0]  data_o,
  input logic          done_o,
  input logic          corrected_o,
  input logic          uncorrectable_o
);
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);  // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(corrected_o && uncorrectable_o));  // R8
  AST_ONE_FLIP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_i |=> ($countones(data_o ^ $past(data_o)) <= 1));  // R9
  AST_BUDGET_STOP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_i && round_i == KW'(ROUNDS)) |=> $stable(data_o));  // R9
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!busy_i && !start_i) |=> $stable(data_o));  // R2
  AST_START_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && !busy_i) |=> (!corrected_o && !uncorrectable_o && !done_o));  // R2
endmodule

bind tcc_corrector tcc_checker #(.N(N), .ROUNDS(ROUNDS), .KW(KW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .start_i        (start_i),
  .busy_i         (busy),
  .round_i        (round_q),
  .data_o         (data_o),
  .done_o         (done_o),
  .corrected_o    (corrected_o),
  .uncorrectable_o(uncorrectable_o)
);

// File: tb/sim_tcc_corrector.sv
`timescale 1ns/1ps
module sim_tcc_corrector;
  localparam int SIDE = 8;
  localparam int N    = 64;
  localparam int ND   = 15;

  logic clk_i = 1'b0, rst_ni = 1'b0, start_i = 1'b0;
  logic [N-1:0] data_i = '0;
  logic [SIDE-1:0] row_syn_i = '0, col_syn_i = '0;
  logic [ND-1:0] rise_syn_i = '0, fall_syn_i = '0;
  logic [3:0] dir_bad_i = '0;
  logic [N-1:0] data_o;
  logic done_o, corrected_o, uncorrectable_o;

  int n_cmp = 0, n_bad = 0, cyc = 0;

  always #2.5 clk_i = ~clk_i;

  tcc_corrector u0 (.*);

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc > 150000) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: act cycles=%0d exp<150000", cyc);
      finish_run();
    end
  end

  task automatic check(string req, logic [N-1:0] act, logic [N-1:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: act=%h exp=%h", req, act, exp);
    end
  endtask

  function automatic logic [N-1:0] gold(int k);
    return 64'h0123_4567_89AB_CDEF ^ (64'(k) * 64'h9E37_79B9_7F4A_7C15);
  endfunction

  // one problem: syndromes from the error mask, masked dirs fed all ones
  task automatic run(string req, logic [N-1:0] g, logic [N-1:0] err, logic [3:0] bad,
                     logic [N-1:0] exp_d, logic exp_c, logic exp_u, int exp_lat);
    logic [SIDE-1:0] r, c;
    logic [ND-1:0] s, b;
    int lat;
    r = '0; c = '0; s = '0; b = '0;
    for (int i = 0; i < N; i++)
      if (err[i]) begin
        r[i/8] ^= 1'b1;
        c[i%8] ^= 1'b1;
        s[i/8 + i%8] ^= 1'b1;
        b[i/8 - i%8 + 7] ^= 1'b1;
      end
    @(negedge clk_i);
    data_i     = g ^ err;
    row_syn_i  = bad[0] ? '1 : r;
    col_syn_i  = bad[1] ? '1 : c;
    rise_syn_i = bad[2] ? '1 : s;
    fall_syn_i = bad[3] ? '1 : b;
    dir_bad_i  = bad;
    start_i    = 1'b1;
    @(negedge clk_i);
    start_i = 1'b0;
    lat = 1;
    while (!done_o && lat < 12) begin
      @(negedge clk_i);
      lat++;
    end
    check({req, " data"}, data_o, exp_d);
    check({req, " flags"}, 64'({corrected_o, uncorrectable_o}), 64'({exp_c, exp_u}));
    check("R2 latency", 64'(lat), 64'(exp_lat));
  endtask

  initial begin
    #1;
    check("R1 data", data_o, '0);
    check("R1 flags", 64'({done_o, corrected_o, uncorrectable_o}), '0);
    #10 rst_ni = 1'b1;
    // R6: clean word
    run("R6 clean", gold(1), '0, 4'b0000, gold(1), 1'b0, 1'b0, 2);
    // R3: every single error
    for (int i = 0; i < N; i++)
      run("R3 single", gold(i), 64'd1 << i, 4'b0000, gold(i), 1'b1, 1'b0, 3);
    // R4: every pair of errors
    for (int i = 0; i < N; i++)
      for (int j = i + 1; j < N; j++)
        run("R4 pair", gold(i + j), (64'd1 << i) | (64'd1 << j), 4'b0000,
            gold(i + j), 1'b1, 1'b0, 4);
    // R5 / R6: single error with masked directions
    for (int m = 1; m < 15; m++)
      for (int i = 0; i < N; i++) begin
        logic [3:0] bad;
        bad = 4'(m);
        if ($countones(bad) <= 2)
          run("R5 masked", gold(i + 7), 64'd1 << i, bad, gold(i + 7), 1'b1, 1'b0, 3);
        else
          run("R6 one line", gold(i + 7), 64'd1 << i, bad, gold(i + 7) ^ (64'd1 << i),
              1'b0, 1'b0, 2);
      end
    // R7: flagged lines with no crossing
    begin
      @(negedge clk_i);
      data_i = gold(3); row_syn_i = 8'hFF; col_syn_i = '0;
      rise_syn_i = '0; fall_syn_i = '0; dir_bad_i = '0; start_i = 1'b1;
      @(negedge clk_i); start_i = 1'b0;
      @(negedge clk_i);
      check("R7 data", data_o, gold(3));
      check("R7 flags", 64'({done_o, corrected_o, uncorrectable_o}), 64'(3'b101));
      @(negedge clk_i);
      check("R8 done pulse", 64'(done_o), 64'd0);
      repeat (3) @(negedge clk_i);
      check("R2 idle hold", data_o, gold(3));
    end
    finish_run();
  end
endmodule